// File: doc/BRIEF.md
# Configuration PROM Image CRC-8 Checker

This block validates an image of 16-bit words that a loader has already fetched from a board configuration PROM. Words are presented one per accepted beat on a valid/ready stream, with a marker on the final word. The checker folds the bytes of the image into an eight-bit CRC, one byte per clock. It then compares the result with the check byte carried in the final word and reports whether the image is intact.

Alongside the pass/fail flag the block reports the revision number held in the final word. It also reports whether the image had the long length used by newer revisions. Images of exactly two lengths are accepted: a short length for older revisions and a long length of 220 words. Any other length fails even when the CRC matches. Because each ordinary word contributes two bytes, the block pauses the stream for one cycle after every word except the final one.

Top module: `prom_crc_checker`

## Requirements
- R1: After reset `res_done`, `res_pass`, `res_long` and `res_rev` are 0 and `in_ready` is 1.
- R2: The CRC register is loaded with 0xFF at the first accepted word of an image. Each byte b updates it as crc = F(crc XOR b). F shifts right eight times and XORs 0xAB whenever the bit shifted out is 1 (the bit-reversed form of x^8+x^7+x^6+x^4+x^2+1), so F(0x01)=0xF7 and F(0x02)=0xB9.
- R3: For every word except the final one, bits [7:0] are folded into the CRC before bits [15:8].
- R4: For the final word (`in_last`=1), only bits [7:0] enter the CRC. Bits [15:8] are the expected check value.
- R5: The CRC is XORed with 0xFF before it is compared. `res_pass` is 1 only when the result equals bits [15:8] of the final word and R8 holds.
- R6: `res_rev` equals bits [7:0] of the final word.
- R7: After an ordinary word is accepted, `in_ready` is 0 for exactly one cycle and then returns to 1. Accepting a final word does not lower `in_ready`.
- R8: The image must contain exactly SHORT_WORDS (default 64) or LONG_WORDS (default 220) words, final word included, or `res_pass` is 0. `res_long` is 1 exactly when the count is LONG_WORDS.
- R9: The results appear on the clock edge that accepts the final word. They are held until the next word is accepted, and that word clears `res_done` and `res_pass`.
- R10: `in_valid` asserted while `in_ready` is 0 has no effect on the CRC, the word count or the results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Word on `in_word` is offered |
| in_word | input | 16 | Image word |
| in_last | input | 1 | Offered word is the final word of the image |
| in_ready | output | 1 | Block can accept a word this cycle |
| res_done | output | 1 | Results of the last image are valid |
| res_pass | output | 1 | CRC matched and length was legal |
| res_long | output | 1 | Image had LONG_WORDS words |
| res_rev | output | 8 | Revision byte of the final word |

## Verification
The embedded assertions check the stream timing on every cycle. They cover the single-cycle stall after each ordinary word, the absence of a stall after a final word, the rise of `res_done` only on a final-word acceptance, and the holding of the results while no word is taken. Only the bench's scenarios can show that the CRC value is right. They exercise the byte order within a word, the exclusion of the check byte, the final complement, the length rule and the ignoring of beats offered during a stall, across many generated images of both legal lengths and several illegal ones.

// File: rtl/prom_crc_pkg.sv
package prom_crc_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  // Bit-reversed x^8+x^7+x^6+x^4+x^2+1
  localparam logic [BYTE_W-1:0] POLY_REFL = 8'hAB;
  localparam logic [BYTE_W-1:0] CRC_SEED  = 8'hFF;
  localparam logic [BYTE_W-1:0] CRC_XOUT  = 8'hFF;
endpackage

// File: rtl/prom_crc_byte_step.sv
module prom_crc_byte_step
  import prom_crc_pkg::*;
#(
  parameter logic [BYTE_W-1:0] POLY = POLY_REFL
) (
  input  logic [BYTE_W-1:0] crc_in,
  input  logic [BYTE_W-1:0] data_in,
  output logic [BYTE_W-1:0] crc_out
);
  logic [BYTE_W-1:0] stage [0:BYTE_W];

  assign stage[0] = crc_in ^ data_in;

  for (genvar k = 0; k < BYTE_W; k++) begin : g_shift
    assign stage[k+1] = stage[k][0] ? ((stage[k] >> 1) ^ POLY) : (stage[k] >> 1);
  end

  assign crc_out = stage[BYTE_W];
endmodule

// File: rtl/prom_crc_len_check.sv
module prom_crc_len_check #(
  parameter int SHORT_WORDS = 64,
  parameter int LONG_WORDS  = 220
) (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic take_last,
  output logic size_ok,
  output logic is_long
);
  localparam int MAXW = (LONG_WORDS > SHORT_WORDS) ? LONG_WORDS : SHORT_WORDS;
  localparam int CW   = $clog2(MAXW + 2);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_next;

  assign cnt_next = (cnt_q == CMAX) ? CMAX : cnt_q + 1'b1;
  assign size_ok  = (cnt_next == CW'(SHORT_WORDS)) || (cnt_next == CW'(LONG_WORDS));
  assign is_long  = (cnt_next == CW'(LONG_WORDS));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (take) begin
      cnt_q <= take_last ? '0 : cnt_next;
    end
  end
endmodule

// File: rtl/prom_crc_checker.sv
module prom_crc_checker
  import prom_crc_pkg::*;
#(
  parameter int SHORT_WORDS = 64,
  parameter int LONG_WORDS  = 220
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_last,
  output logic              in_ready,
  output logic              res_done,
  output logic              res_pass,
  output logic              res_long,
  output logic [BYTE_W-1:0] res_rev
);
  logic              hi_pending;
  logic              first_word;
  logic [BYTE_W-1:0] crc_q;
  logic [BYTE_W-1:0] hi_hold;
  logic [BYTE_W-1:0] step_crc;
  logic [BYTE_W-1:0] step_data;
  logic [BYTE_W-1:0] step_out;
  logic              take;
  logic              len_ok;
  logic              len_long;

  assign in_ready = !hi_pending;
  assign take     = in_valid && in_ready;

  assign step_crc  = hi_pending ? crc_q : (first_word ? CRC_SEED : crc_q);
  assign step_data = hi_pending ? hi_hold : in_word[BYTE_W-1:0];

  prom_crc_byte_step #(.POLY(POLY_REFL)) u_step (
    .crc_in  (step_crc),
    .data_in (step_data),
    .crc_out (step_out)
  );

  prom_crc_len_check #(
    .SHORT_WORDS (SHORT_WORDS),
    .LONG_WORDS  (LONG_WORDS)
  ) u_len (
    .clk       (clk),
    .rst       (rst),
    .take      (take),
    .take_last (in_last),
    .size_ok   (len_ok),
    .is_long   (len_long)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_pending <= 1'b0;
      first_word <= 1'b1;
      crc_q      <= CRC_SEED;
      hi_hold    <= '0;
      res_done   <= 1'b0;
      res_pass   <= 1'b0;
      res_long   <= 1'b0;
      res_rev    <= '0;
    end else if (hi_pending) begin
      crc_q      <= step_out;
      hi_pending <= 1'b0;
    end else if (take) begin
      first_word <= in_last;
      if (in_last) begin
        crc_q    <= step_out;
        res_done <= 1'b1;
        res_pass <= ((step_out ^ CRC_XOUT) == in_word[WORD_W-1:BYTE_W]) && len_ok;
        res_long <= len_long;
        res_rev  <= in_word[BYTE_W-1:0];
      end else begin
        crc_q      <= step_out;
        hi_hold    <= in_word[WORD_W-1:BYTE_W];
        hi_pending <= 1'b1;
        res_done   <= 1'b0;
        res_pass   <= 1'b0;
      end
    end
  end

  // R7: one stall cycle after an ordinary word
  a_r7_stall_after_word: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !in_last) |=> !in_ready);
  // R7: the stall lasts a single cycle
  a_r7_stall_one_cycle: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> in_ready);
  // R7: no stall after a final word
  a_r7_no_stall_last: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_last) |=> in_ready);
  // R9: results appear only on a final-word acceptance
  a_r9_done_source: assert property (@(posedge clk) disable iff (rst)
    $rose(res_done) |-> $past(in_valid && in_ready && in_last));
  // R9: results held while no word is taken
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (res_done && !(in_valid && in_ready)) |=>
      (res_done && $stable(res_pass) && $stable(res_rev) && $stable(res_long)));
  // R5: pass only accompanies valid results
  a_r5_pass_needs_done: assert property (@(posedge clk) disable iff (rst)
    res_pass |-> res_done);
endmodule

// File: tb/sim_prom_crc_checker.sv
module sim_prom_crc_checker;
  localparam int CLK_PERIOD = 10;
  localparam int SHORT_W = 64;
  localparam int LONG_W  = 220;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_word = '0;
  logic        in_last = 1'b0;
  logic        in_ready;
  logic        res_done, res_pass, res_long;
  logic [7:0]  res_rev;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prom_crc_checker #(.SHORT_WORDS(SHORT_W), .LONG_WORDS(LONG_W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .in_last(in_last), .in_ready(in_ready), .res_done(res_done),
    .res_pass(res_pass), .res_long(res_long), .res_rev(res_rev)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R2: byte update from the requirement text
  function automatic logic [7:0] fstep(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] v = c ^ b;
    for (int i = 0; i < 8; i++) v = v[0] ? ((v >> 1) ^ 8'hAB) : (v >> 1);
    return v;
  endfunction

  function automatic logic [15:0] body_word(input int seed, input int i);
    return 16'((seed * 40503 + i * 9973 + (i * i) * 31) ^ (i << 7));
  endfunction

  // expected check byte over n-1 ordinary words and the low byte of the final word
  function automatic logic [7:0] exp_crc(input int seed, input int n, input logic [7:0] rev);
    logic [7:0] c = 8'hFF;
    for (int i = 0; i < n - 1; i++) begin
      logic [15:0] w = body_word(seed, i);
      c = fstep(c, w[7:0]);
      c = fstep(c, w[15:8]);
    end
    c = fstep(c, rev);
    return c ^ 8'hFF;
  endfunction

  task automatic send(input logic [15:0] w, input logic last, input logic junk);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_word = w; in_last = last;
    @(posedge clk); #1;
    in_valid = 1'b0;
    if (!last) begin
      @(negedge clk);
      chk("R7 ready low after word", {31'b0, in_ready}, 32'd0);
      if (junk) begin
        // R10: beat offered during the stall must be ignored
        in_valid = 1'b1; in_word = 16'hDEAD ^ w; in_last = 1'b1;
        @(posedge clk); #1;
        in_valid = 1'b0; in_last = 1'b0;
      end
    end else begin
      @(negedge clk);
      chk("R7 no stall after final word", {31'b0, in_ready}, 32'd1);
    end
  endtask

  task automatic run_image(input string tag, input int seed, input int n,
                           input logic [7:0] rev, input logic corrupt,
                           input logic junk, input logic exp_pass);
    logic [7:0] cb = exp_crc(seed, n, rev) ^ (corrupt ? 8'h01 : 8'h00);
    for (int i = 0; i < n - 1; i++) begin
      send(body_word(seed, i), 1'b0, junk && (i % 5 == 2));
      if (i == 0) chk({tag, " R9 done cleared by next word"}, {31'b0, res_done}, 32'd0);
    end
    send({cb, rev}, 1'b1, 1'b0);
    chk({tag, " R9 done"}, {31'b0, res_done}, 32'd1);
    chk({tag, " R5 pass"}, {31'b0, res_pass}, {31'b0, exp_pass});
    chk({tag, " R6 revision"}, {24'b0, res_rev}, {24'b0, rev});
    chk({tag, " R8 long flag"}, {31'b0, res_long}, {31'b0, n == LONG_W});
    repeat (3) @(negedge clk);
    chk({tag, " R9 held"}, {30'b0, res_done, res_pass}, {30'b0, 1'b1, exp_pass});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", {31'b0, in_ready}, 32'd1);
    chk("R1 done", {31'b0, res_done}, 32'd0);
    chk("R1 pass", {31'b0, res_pass}, 32'd0);
    chk("R1 long", {31'b0, res_long}, 32'd0);
    chk("R1 rev", {24'b0, res_rev}, 32'd0);

    // R2 R3 R4 R5: good images of both lengths, many seeds and revisions
    for (int s = 0; s < 6; s++) begin
      run_image("R2 R3 short good", s, SHORT_W, 8'(1 + s % 3), 1'b0, 1'b0, 1'b1);
      run_image("R2 R4 long good", s + 17, LONG_W, 8'(4 + s), 1'b0, 1'b0, 1'b1);
    end
    // R5: corrupted check byte fails
    run_image("R5 short bad crc", 3, SHORT_W, 8'h02, 1'b1, 1'b0, 1'b0);
    run_image("R5 long bad crc", 9, LONG_W, 8'h05, 1'b1, 1'b0, 1'b0);
    // R8: correct CRC but illegal lengths
    run_image("R8 len 63", 4, SHORT_W - 1, 8'h01, 1'b0, 1'b0, 1'b0);
    run_image("R8 len 65", 4, SHORT_W + 1, 8'h01, 1'b0, 1'b0, 1'b0);
    run_image("R8 len 219", 5, LONG_W - 1, 8'h04, 1'b0, 1'b0, 1'b0);
    run_image("R8 len 1", 6, 1, 8'h07, 1'b0, 1'b0, 1'b0);
    // R10: junk beats during stalls are ignored
    run_image("R10 short junk", 11, SHORT_W, 8'h03, 1'b0, 1'b1, 1'b1);
    run_image("R10 long junk", 12, LONG_W, 8'h06, 1'b0, 1'b1, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule